// File: doc/BRIEF.md
# Finite-Field Multiplier with Concurrent Parity Checking

This block multiplies two elements of GF(2^m) held in polynomial basis, reducing by a fixed irreducible polynomial given as a parameter. The product datapath is bit-parallel and has two networks. The first is a ladder of multiply-by-x stages that builds every shifted and reduced copy A·x^i mod F. The second selects each copy with operand bit b_i and XOR-sums the selected copies. The product, the parity bits and an alarm are captured in one output register, so results appear one clock after the operands.

Alongside the datapath, a parity-prediction chain follows the ladder. Each stage updates an r-bit parity vector from the previous vector, the top coordinate leaving that stage and constant group parities of the polynomial. The predicted parities are selected and summed by the same operand bits. A separate tree computes the actual parities of the product. Any disagreement raises the alarm. A test-only port can override one coordinate of any ladder output, so a checker or a bench can show that the alarm responds to a corrupted datapath.

Top module: `gfp_pmul_ced`

## Requirements
- R1: While `rst_n` is low, `prod`, `par_pred`, `par_act` and `err` are all zero.
- R2: When `flt_en` is low, `prod` equals opa·opb reduced modulo POLY, one clock after the operands are sampled.
- R3: Parity bit j of a vector is the XOR of every coordinate whose index is congruent to j modulo R (interleaved groups). `par_act` is this parity of `prod`.
- R4: If `opb` is zero, `prod` and `par_pred` are zero on the next cycle.
- R5: Each ladder stage predicts its output parity as follows. Bit j is the previous bit (j−1) mod R XOR (outgoing top coordinate AND the group-j parity of the polynomial's low terms). Group m mod R is additionally inverted by the outgoing top coordinate. With `opb` = 2^i, `par_pred` equals the R3 parity of opa·x^i mod POLY.
- R6: `err` is 1 exactly when `par_pred` and `par_act` differ in at least one bit. With `flt_en` low it stays 0.
- R7: When `flt_en` is high, coordinate `flt_bit` of ladder output A^(`flt_idx`) is replaced by `flt_val` (index 0 is opa itself). Later stages and the sum use the replaced value, but the parity chain starts from the unreplaced value. A flip with b_i set and no higher set operand bit raises `err`.
- R8: A replacement that writes a coordinate's own current value has no effect on `prod` and leaves `err` at 0.
- R9: With `opb` equal to 1 and `flt_en` low, `prod` equals `opa`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa | input | M | Multiplicand A |
| opb | input | M | Multiplier B |
| flt_en | input | 1 | Test-only: enable coordinate override |
| flt_idx | input | IW | Test-only: ladder output to override |
| flt_bit | input | IW | Test-only: coordinate to override |
| flt_val | input | 1 | Test-only: value forced onto that coordinate |
| prod | output | M | Registered product C |
| par_pred | output | R | Registered predicted parity of C |
| par_act | output | R | Registered actual parity of C |
| err | output | 1 | Registered parity mismatch alarm |

## Verification
Random operand pairs are compared against a shift-and-reduce model, so any mismatch points to a ladder or summation error. Single-bit multipliers 2^i isolate one ladder stage at a time, so a wrong rotation or a missing top-bit correction shows up at that stage. Zero, one, all-ones and top-bit-only operands probe the reduction edges. Overrides that flip a coordinate, with the multiplier chosen so the flip cannot cancel, are told apart from overrides that rewrite the same value, because only the flips may raise the alarm.

// File: rtl/gfp_pkg.sv
package gfp_pkg;

    // Parity group that a coordinate position belongs to (interleaved grouping).
    function automatic int unsigned grp_of(input int unsigned pos, input int unsigned nr);
        return pos % nr;
    endfunction

endpackage

// File: rtl/gfp_parity.sv
module gfp_parity #(
    parameter int unsigned M = 8,
    parameter int unsigned R = 3
) (
    input  logic [M-1:0] vec,
    output logic [R-1:0] par
);
    for (genvar g = 0; g < R; g++) begin : g_grp
        always_comb begin
            par[g] = 1'b0;
            for (int k = g; k < int'(M); k += int'(R)) begin
                par[g] = par[g] ^ vec[k];
            end
        end
    end
endmodule

// File: rtl/gfp_fault.sv
module gfp_fault #(
    parameter int unsigned M  = 8,
    parameter int unsigned IW = 3
) (
    input  logic [M-1:0]  vec_in,
    input  logic          hit,
    input  logic [IW-1:0] bit_sel,
    input  logic          val,
    output logic [M-1:0]  vec_out
);
    always_comb begin
        vec_out = vec_in;
        for (int k = 0; k < int'(M); k++) begin
            if (hit && (bit_sel == IW'(k))) begin
                vec_out[k] = val;
            end
        end
    end
endmodule

// File: rtl/gfp_xstage.sv
module gfp_xstage #(
    parameter int unsigned M    = 8,
    parameter int unsigned R    = 3,
    parameter logic [M:0]  POLY = 9'h11B
) (
    input  logic [M-1:0] a_in,
    input  logic [R-1:0] p_in,
    output logic [M-1:0] a_out,
    output logic [R-1:0] p_out
);
    localparam logic [M-1:0] FLOW = POLY[M-1:0];
    localparam int unsigned  J0   = gfp_pkg::grp_of(M, R);

    logic         top;
    logic [R-1:0] fpar;
    logic [R-1:0] fcorr;

    assign top = a_in[M-1];

    // Constant group parities of the reduction terms.
    gfp_parity #(.M(M), .R(R)) u_fpar (.vec(FLOW), .par(fpar));

    // Datapath: shift up one and fold the dropped top coordinate back in.
    always_comb begin
        a_out = {a_in[M-2:0], 1'b0};
        if (top) begin
            a_out = a_out ^ FLOW;
        end
    end

    // Prediction: rotate groups, then correct with the polynomial's parities.
    for (genvar g = 0; g < R; g++) begin : g_pred
        localparam int unsigned SRC = (g + R - 1) % R;
        assign fcorr[g] = fpar[g] ^ (g == int'(J0));
        assign p_out[g] = p_in[SRC] ^ (top & fcorr[g]);
    end
endmodule

// File: rtl/gfp_accum.sv
module gfp_accum #(
    parameter int unsigned M = 8,
    parameter int unsigned R = 3
) (
    input  logic [M-1:0][M-1:0] ax,
    input  logic [M-1:0][R-1:0] px,
    input  logic [M-1:0]        b,
    output logic [M-1:0]        c,
    output logic [R-1:0]        pp
);
    always_comb begin
        c  = '0;
        pp = '0;
        for (int i = 0; i < int'(M); i++) begin
            if (b[i]) begin
                c  = c ^ ax[i];
                pp = pp ^ px[i];
            end
        end
    end
endmodule

// File: rtl/gfp_pmul_ced.sv
module gfp_pmul_ced #(
    parameter int unsigned M    = 8,
    parameter int unsigned R    = 3,
    parameter logic [M:0]  POLY = 9'h11B,
    localparam int unsigned IW  = (M > 1) ? $clog2(M) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [M-1:0]  opa,
    input  logic [M-1:0]  opb,
    input  logic          flt_en,
    input  logic [IW-1:0] flt_idx,
    input  logic [IW-1:0] flt_bit,
    input  logic          flt_val,
    output logic [M-1:0]  prod,
    output logic [R-1:0]  par_pred,
    output logic [R-1:0]  par_act,
    output logic          err
);
    typedef struct packed {
        logic [M-1:0] prod;
        logic [R-1:0] pred;
        logic [R-1:0] act;
        logic         err;
    } res_t;

    res_t res_d, res_q;

    logic [M-1:0][M-1:0] raw;
    logic [M-1:0][M-1:0] ax;
    logic [M-1:0][R-1:0] px;
    logic [M-1:0]        c_sum;
    logic [R-1:0]        pp_sum;
    logic [R-1:0]        pa_sum;

    assign raw[0] = opa;
    gfp_parity #(.M(M), .R(R)) u_p0 (.vec(opa), .par(px[0]));

    // Ladder of multiply-by-x stages, each output passing the test override.
    for (genvar i = 0; i < int'(M); i++) begin : g_node
        gfp_fault #(.M(M), .IW(IW)) u_flt (
            .vec_in (raw[i]),
            .hit    (flt_en && (flt_idx == IW'(i))),
            .bit_sel(flt_bit),
            .val    (flt_val),
            .vec_out(ax[i])
        );
        if (i > 0) begin : g_stage
            gfp_xstage #(.M(M), .R(R), .POLY(POLY)) u_xs (
                .a_in (ax[i-1]),
                .p_in (px[i-1]),
                .a_out(raw[i]),
                .p_out(px[i])
            );
        end
    end

    gfp_accum #(.M(M), .R(R)) u_acc (
        .ax(ax), .px(px), .b(opb), .c(c_sum), .pp(pp_sum)
    );

    gfp_parity #(.M(M), .R(R)) u_pact (.vec(c_sum), .par(pa_sum));

    always_comb begin
        res_d      = res_q;
        res_d.prod = c_sum;
        res_d.pred = pp_sum;
        res_d.act  = pa_sum;
        res_d.err  = |(pp_sum ^ pa_sum);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign prod     = res_q.prod;
    assign par_pred = res_q.pred;
    assign par_act  = res_q.act;
    assign err      = res_q.err;

    // R1: outputs held clear during reset
    p_reset_clear_r1: assert property (@(posedge clk)
        (!rst_n && $past(!rst_n)) |-> (res_q == '0));

    // R6: without an override the alarm never rises
    p_clean_no_alarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_en |=> !err);

    // R4: zero multiplier gives zero product and zero predicted parity
    p_zero_mult_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (opb == '0) |=> (prod == '0 && par_pred == '0));

    // R9: unit multiplier passes the multiplicand through
    p_unit_mult_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (opb == M'(1) && !flt_en) |=> (prod == $past(opa)));

    // R2: zero multiplicand gives zero product
    p_zero_mcand_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (opa == '0 && !flt_en) |=> (prod == '0));
endmodule

// File: tb/sim_gfp_pmul_ced.sv
module sim_gfp_pmul_ced;
    localparam int unsigned M    = 8;
    localparam int unsigned R    = 3;
    localparam logic [M:0]  POLY = 9'h11B;
    localparam int unsigned IW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [M-1:0]  opa = '0;
    logic [M-1:0]  opb = '0;
    logic          flt_en = 1'b0;
    logic [IW-1:0] flt_idx = '0;
    logic [IW-1:0] flt_bit = '0;
    logic          flt_val = 1'b0;
    logic [M-1:0]  prod;
    logic [R-1:0]  par_pred;
    logic [R-1:0]  par_act;
    logic          err;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    gfp_pmul_ced #(.M(M), .R(R), .POLY(POLY)) u0 (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb),
        .flt_en(flt_en), .flt_idx(flt_idx), .flt_bit(flt_bit), .flt_val(flt_val),
        .prod(prod), .par_pred(par_pred), .par_act(par_act), .err(err)
    );

    // Carry-less product followed by top-down reduction.
    function automatic logic [M-1:0] gmul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [2*M-2:0] t;
        t = '0;
        for (int i = 0; i < int'(M); i++)
            if (b[i]) t = t ^ ((2*M-1)'(a) << i);
        for (int k = 2*M-2; k >= int'(M); k--)
            if (t[k]) t = t ^ ((2*M-1)'(POLY) << (k - int'(M)));
        return t[M-1:0];
    endfunction

    function automatic logic [R-1:0] gpar(input logic [M-1:0] v);
        logic [R-1:0] p;
        p = '0;
        for (int k = 0; k < int'(M); k++) p[k % int'(R)] = p[k % int'(R)] ^ v[k];
        return p;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Drive one vector, wait for the register, compare all outputs.
    task automatic run(input logic [M-1:0] a, input logic [M-1:0] b, input logic fen,
                       input int fi, input int fb, input logic fv, input string tag,
                       input logic chk_pred_exact);
        logic [M-1:0] exp_c, ai, aif;
        logic [R-1:0] dsum, exp_pa;
        logic flip;
        opa = a; opb = b; flt_en = fen;
        flt_idx = IW'(fi); flt_bit = IW'(fb); flt_val = fv;
        exp_c = '0; dsum = '0; flip = 1'b0;
        if (!fen) begin
            exp_c = gmul(a, b);
        end else begin
            ai   = gmul(a, M'(1) << fi);
            aif  = ai;
            aif[fb] = fv;
            flip = (aif != ai);
            for (int k = 0; k < int'(M); k++) begin
                if (b[k]) begin
                    if (k < fi) exp_c = exp_c ^ gmul(a, M'(1) << k);
                    else begin
                        exp_c = exp_c ^ gmul(aif, M'(1) << (k - fi));
                        if (flip) dsum[(fb + k - fi) % int'(R)] = ~dsum[(fb + k - fi) % int'(R)];
                    end
                end
            end
        end
        exp_pa = gpar(exp_c);
        @(negedge clk);
        chk(tag, "prod", int'(prod), int'(exp_c));
        chk("R3", "par_act", int'(par_act), int'(exp_pa));
        if (chk_pred_exact) chk(tag, "par_pred", int'(par_pred), int'(exp_pa ^ dsum));
        chk("R6", "err", int'(err), int'(dsum != '0));
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [M-1:0] a, b, ax;
        repeat (3) @(negedge clk);
        chk("R1", "prod", int'(prod), 0);
        chk("R1", "err", int'(err), 0);
        chk("R1", "par_act", int'(par_act), 0);
        chk("R1", "par_pred", int'(par_pred), 0);
        rst_n = 1'b1;

        // R2: random operand pairs
        for (int n = 0; n < 300; n++) begin
            a = M'($urandom); b = M'($urandom);
            run(a, b, 1'b0, 0, 0, 1'b0, "R2", 1'b1);
        end
        // R4: zero multiplier; R9: unit multiplier; reduction edges
        run(8'hA7, 8'h00, 1'b0, 0, 0, 1'b0, "R4", 1'b1);
        run(8'h5C, 8'h01, 1'b0, 0, 0, 1'b0, "R9", 1'b1);
        run(8'h80, 8'h80, 1'b0, 0, 0, 1'b0, "R2", 1'b1);
        run(8'hFF, 8'hFF, 1'b0, 0, 0, 1'b0, "R2", 1'b1);
        run(8'h00, 8'hC3, 1'b0, 0, 0, 1'b0, "R2", 1'b1);
        run(8'h53, 8'hCA, 1'b0, 0, 0, 1'b0, "R2", 1'b1);

        // R5: single-bit multiplier isolates each ladder stage
        for (int i = 0; i < int'(M); i++) begin
            for (int n = 0; n < 6; n++) begin
                a = (n == 0) ? 8'h80 : M'($urandom);
                run(a, M'(1) << i, 1'b0, 0, 0, 1'b0, "R5", 1'b1);
            end
        end

        // R7: flips that cannot cancel raise the alarm
        for (int i = 0; i < int'(M); i++) begin
            for (int bt = 0; bt < int'(M); bt++) begin
                a  = M'($urandom);
                b  = (M'($urandom) & ((M'(1) << i) - M'(1))) | (M'(1) << i);
                ax = gmul(a, M'(1) << i);
                run(a, b, 1'b1, i, bt, ~ax[bt], "R7", 1'b1);
                chk("R7", "err_forced", int'(err), 1);
            end
        end

        // R8: rewriting the same value changes nothing
        for (int n = 0; n < 40; n++) begin
            int fi, fb;
            a = M'($urandom); b = M'($urandom);
            fi = $urandom % M; fb = $urandom % M;
            ax = gmul(a, M'(1) << fi);
            run(a, b, 1'b1, fi, fb, ax[fb], "R8", 1'b1);
            chk("R8", "prod_same", int'(prod), int'(gmul(a, b)));
        end

        // R7: random overrides against the behavioural fault model
        for (int n = 0; n < 100; n++) begin
            int fi, fb;
            a = M'($urandom); b = M'($urandom);
            fi = $urandom % M; fb = $urandom % M;
            run(a, b, 1'b1, fi, fb, 1'($urandom), "R7", 1'b1);
        end

        flt_en = 1'b0;
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule